// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block sequences the control lines of a small accumulator processor. An 8-bit micro-program counter selects one word of a 256 x 16 constant control store, and that word is presented as the control word for the datapath. Thirteen of the sixteen bits drive datapath control lines. Examples are the accumulator load, the program counter driving the bus, the memory-address load and the PC increment. The three spare bits always read zero.

Every instruction begins with the same two fetch states. The third state is a dispatch point. There the counter takes a start address chosen by the opcode held in the instruction register. Each execute routine ends with an all-zero word, and reading that word sends the counter back to the first fetch state.

The counter moves on the falling clock edge. The datapath registers capture on the rising edge, so each control word is settled half a cycle before it is used. A halt opcode freezes the sequencer with every control line low until reset.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous active-high reset, sampled on the falling edge, sets the micro counter to 0 and clears the halt state. The control word is then 0x3000, the first fetch state.
- R2: From address 0 the counter steps to address 1, and `ctrl_word` becomes 0x0A80 (RAM to bus, IR load, PC increment). It then steps to address 2.
- R3: Control positions are numbered from the most significant bit, so position p is bit 15−p. The positions are: 0 accumulator to bus, 1 accumulator load, 2 PC to bus, 3 MAR load, 4 RAM to bus, 5 RAM write, 6 IR load, 7 IR operand to bus, 8 PC increment, 9 ALU to bus, 10 B load, 11 output load, 12 PC load. Bits 2..0 are always 0.
- R4: The store holds the following words: 0:0x3000, 1:0x0A80, 3:0x3000, 4:0x4880, 6:0x4040, 8:0x1100, 9:0x8400. Every other address holds 0.
- R5: On the falling edge with the counter at 2, the counter loads an address chosen by `opcode`: 1→3, 2→6, 3→8. For 0 and for every other opcode except 0xF, it loads 0, so the instruction does nothing.
- R6: At address 2 the word is all zero. The dispatch load takes precedence over the zero-word restart at that address.
- R7: At any address other than 2, an all-zero word returns the counter to 0 on the next falling edge.
- R8: If `opcode` is 0xF at the dispatch edge, the sequencer halts. The counter freezes and `ctrl_word` stays 0 whatever `opcode` does, until reset.
- R9: The counter changes only on the falling edge. `ctrl_word` is combinational from the counter and is stable across the rising edge.
- R10: Reset taken in the middle of an execute routine abandons it. After the next falling edge the word is that of address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| opcode | input | 4 | Opcode held in the instruction register |
| ctrl_word | output | 16 | Control word for the datapath, position p at bit 15−p |

## Verification
The counter and the halt flag update on a falling edge. The control word follows combinationally, so each result is due at the rising edge that comes half a cycle later. The opcode and reset are read only on falling edges. Their effect therefore shows at the first rising edge after the falling edge on which they were sampled, which is one rising edge after they were driven. The bench drives inputs 1 ns after a rising edge and compares on the rising edge itself. It also captures the word 1 ns after each falling edge and requires the same value at the following rising edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CW_WIDTH   = 16;
  localparam int ADDR_WIDTH = 8;
  localparam int OP_WIDTH   = 4;

  // control line positions, counted from the MSB
  localparam int P_ACC_OUT  = 0;
  localparam int P_ACC_LD   = 1;
  localparam int P_PC_OUT   = 2;
  localparam int P_MAR_LD   = 3;
  localparam int P_RAM_OUT  = 4;
  localparam int P_RAM_WR   = 5;
  localparam int P_IR_LD    = 6;
  localparam int P_IR_OUT   = 7;
  localparam int P_PC_INC   = 8;
  localparam int P_ALU_OUT  = 9;
  localparam int P_B_LD     = 10;
  localparam int P_OUT_LD   = 11;
  localparam int P_PC_LD    = 12;

  // opcodes
  localparam int OP_NOP = 0;
  localparam int OP_LDA = 1;
  localparam int OP_ADD = 2;
  localparam int OP_STA = 3;
  localparam int OP_HLT = 15;

  // micro addresses
  localparam int UA_FETCH_A = 0;
  localparam int UA_FETCH_B = 1;
  localparam int UA_DISPATCH = 2;
  localparam int UA_LDA     = 3;
  localparam int UA_ADD     = 6;
  localparam int UA_STA     = 8;

  function automatic logic [15:0] line(input int pos);
    return 16'h8000 >> pos;
  endfunction

  function automatic logic [15:0] ucode_word(input int unsigned addr);
    case (addr)
      0:       return line(P_PC_OUT) | line(P_MAR_LD);
      1:       return line(P_RAM_OUT) | line(P_IR_LD) | line(P_PC_INC);
      3:       return line(P_PC_OUT) | line(P_MAR_LD);
      4:       return line(P_RAM_OUT) | line(P_ACC_LD) | line(P_PC_INC);
      6:       return line(P_ALU_OUT) | line(P_ACC_LD);
      8:       return line(P_IR_OUT) | line(P_MAR_LD);
      9:       return line(P_ACC_OUT) | line(P_RAM_WR);
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = useq_pkg::ADDR_WIDTH,
  parameter int CW_W   = useq_pkg::CW_WIDTH
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CW_W-1:0]   word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = CW_W'(useq_pkg::ucode_word(i));
  end

  assign word = mem[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int ADDR_W = useq_pkg::ADDR_WIDTH,
  parameter int OP_W   = useq_pkg::OP_WIDTH
) (
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] target,
  output logic              is_halt
);
  import useq_pkg::*;

  always_comb begin
    is_halt = (opcode == OP_W'(OP_HLT));
    case (opcode)
      OP_W'(OP_LDA): target = ADDR_W'(UA_LDA);
      OP_W'(OP_ADD): target = ADDR_W'(UA_ADD);
      OP_W'(OP_STA): target = ADDR_W'(UA_STA);
      default:       target = ADDR_W'(UA_FETCH_A);
    endcase
  end
endmodule

// File: rtl/useq_counter.sv
module useq_counter #(
  parameter int ADDR_W = useq_pkg::ADDR_WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_zero,
  input  logic              is_halt,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] upc,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] DISPATCH = ADDR_W'(useq_pkg::UA_DISPATCH);

  always_ff @(negedge clk) begin
    if (rst) begin
      upc    <= '0;
      halted <= 1'b0;
    end else if (halted) begin
      upc    <= upc;
    end else if (upc == DISPATCH) begin
      if (is_halt) halted <= 1'b1;
      else         upc    <= target;
    end else if (word_zero) begin
      upc <= '0;
    end else begin
      upc <= upc + 1'b1;
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int ADDR_W = useq_pkg::ADDR_WIDTH,
  parameter int CW_W   = useq_pkg::CW_WIDTH,
  parameter int OP_W   = useq_pkg::OP_WIDTH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic [CW_W-1:0] ctrl_word
);
  logic [ADDR_W-1:0] upc;
  logic              halted;
  logic [CW_W-1:0]   raw_word;
  logic [ADDR_W-1:0] target;
  logic              is_halt;

  useq_store #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_store (
    .addr (upc),
    .word (raw_word)
  );

  useq_dispatch #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_dispatch (
    .opcode  (opcode),
    .target  (target),
    .is_halt (is_halt)
  );

  useq_counter #(.ADDR_W(ADDR_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .word_zero (~|raw_word),
    .is_halt   (is_halt),
    .target    (target),
    .upc       (upc),
    .halted    (halted)
  );

  assign ctrl_word = halted ? '0 : raw_word;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int ADDR_W = 8,
  parameter int CW_W   = 16,
  parameter int OP_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic [CW_W-1:0]   ctrl_word,
  input logic [ADDR_W-1:0] upc,
  input logic              halted
);
  AST_FETCH_STEP: assert property (@(negedge clk) disable iff (rst)
    (upc == ADDR_W'(0) && !halted) |=> (upc == ADDR_W'(1))); // R2

  AST_FETCH_TO_DISPATCH: assert property (@(negedge clk) disable iff (rst)
    (upc == ADDR_W'(1) && !halted) |=> (upc == ADDR_W'(2))); // R2

  AST_DISPATCH_LOAD: assert property (@(negedge clk) disable iff (rst)
    (upc == ADDR_W'(2) && !halted && opcode == OP_W'(1)) |=> (upc == ADDR_W'(3))); // R5

  AST_DISPATCH_STORE: assert property (@(negedge clk) disable iff (rst)
    (upc == ADDR_W'(2) && !halted && opcode == OP_W'(3)) |=> (upc == ADDR_W'(8))); // R5

  AST_DISPATCH_OVER_ZERO: assert property (@(negedge clk) disable iff (rst)
    (upc == ADDR_W'(2) && !halted && opcode == OP_W'(2)) |=> (upc == ADDR_W'(6))); // R6

  AST_ZERO_RESTART: assert property (@(negedge clk) disable iff (rst)
    (!halted && upc != ADDR_W'(2) && ctrl_word == '0) |=> (upc == ADDR_W'(0))); // R7

  AST_HALT_ENTRY: assert property (@(negedge clk) disable iff (rst)
    (!halted && upc == ADDR_W'(2) && opcode == OP_W'(15)) |=> halted); // R8

  AST_HALT_FREEZE: assert property (@(negedge clk) disable iff (rst)
    halted |=> (halted && $stable(upc) && ctrl_word == '0)); // R8
endmodule

bind ucode_sequencer useq_checker #(.ADDR_W(ADDR_W), .CW_W(CW_W), .OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .ctrl_word (ctrl_word),
  .upc       (upc),
  .halted    (halted)
);

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'd1;
  logic [15:0] ctrl_word;
  int n_cmp = 0;
  int n_bad = 0;
  int m_pc = 0;
  bit m_halt = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  ucode_sequencer dut (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .ctrl_word (ctrl_word)
  );

  // expected store contents (R4)
  function automatic logic [15:0] exp_word(input int a);
    case (a)
      0: return 16'h3000;
      1: return 16'h0A80;
      3: return 16'h3000;
      4: return 16'h4880;
      6: return 16'h4040;
      8: return 16'h1100;
      9: return 16'h8400;
      default: return 16'h0000;
    endcase
  endfunction

  // dispatch targets (R5)
  function automatic int exp_target(input logic [3:0] op);
    case (op)
      4'd1: return 3;
      4'd2: return 6;
      4'd3: return 8;
      default: return 0;
    endcase
  endfunction

  // reference sequence from the requirements, stepped on falling edges
  always @(negedge clk) begin
    if (rst) begin
      m_pc = 0; m_halt = 1'b0;
    end else if (!m_halt) begin
      if (m_pc == 2) begin
        if (opcode == 4'hF) m_halt = 1'b1;
        else m_pc = exp_target(opcode);
      end else if (exp_word(m_pc) == 16'h0) m_pc = 0;
      else m_pc = (m_pc + 1) % 256;
    end
  end

  task automatic chk(input logic [15:0] exp, input string tag);
    n_cmp++;
    if (ctrl_word !== exp) begin
      n_bad++;
      $display("FAIL %s: ctrl_word=%h expected %h", tag, ctrl_word, exp);
    end
  endtask

  task automatic step(input logic [15:0] exp, input string tag, input logic nrst, input logic [3:0] nop);
    @(posedge clk);
    chk(exp, tag);
    #1;
    rst = nrst;
    opcode = nop;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] mid;
    void'($urandom(32'd20250418));
    repeat (2) @(posedge clk);
    // LDA pass
    step(16'h3000, "R1", 1'b0, 4'd1);
    step(16'h0A80, "R2", 1'b0, 4'd1);
    step(16'h0000, "R6", 1'b0, 4'd1);
    step(16'h3000, "R5", 1'b0, 4'd1);
    step(16'h4880, "R4", 1'b0, 4'd1);
    step(16'h0000, "R4", 1'b0, 4'd3);
    step(16'h3000, "R7", 1'b0, 4'd3);
    // STA pass
    step(16'h0A80, "R2", 1'b0, 4'd3);
    step(16'h0000, "R6", 1'b0, 4'd3);
    step(16'h1100, "R5", 1'b0, 4'd3);
    step(16'h8400, "R4", 1'b0, 4'd3);
    step(16'h0000, "R4", 1'b0, 4'd2);
    step(16'h3000, "R7", 1'b0, 4'd2);
    // ADD pass
    step(16'h0A80, "R2", 1'b0, 4'd2);
    step(16'h0000, "R6", 1'b0, 4'd2);
    step(16'h4040, "R5", 1'b0, 4'd2);
    step(16'h0000, "R4", 1'b0, 4'd5);
    step(16'h3000, "R7", 1'b0, 4'd5);
    // unknown opcode, then NOP
    step(16'h0A80, "R2", 1'b0, 4'd5);
    step(16'h0000, "R6", 1'b0, 4'd5);
    step(16'h3000, "R5", 1'b0, 4'd0);
    step(16'h0A80, "R2", 1'b0, 4'd0);
    step(16'h0000, "R6", 1'b0, 4'd0);
    step(16'h3000, "R5", 1'b0, 4'hF);
    // halt
    step(16'h0A80, "R2", 1'b0, 4'hF);
    step(16'h0000, "R6", 1'b0, 4'hF);
    step(16'h0000, "R8", 1'b0, 4'd1);
    step(16'h0000, "R8", 1'b0, 4'd1);
    step(16'h0000, "R8", 1'b0, 4'd1);
    step(16'h0000, "R8", 1'b1, 4'd1);
    step(16'h3000, "R1", 1'b0, 4'd1);
    // reset in the middle of LDA
    step(16'h0A80, "R2", 1'b0, 4'd1);
    step(16'h0000, "R6", 1'b0, 4'd1);
    step(16'h3000, "R5", 1'b1, 4'd1);
    step(16'h3000, "R10", 1'b0, 4'd1);
    step(16'h0A80, "R10", 1'b0, 4'd1);

    // random phase against the reference sequence
    for (int i = 0; i < 4000; i++) begin
      int r;
      string tag;
      @(negedge clk);
      #1 mid = ctrl_word;
      @(posedge clk);
      tag = m_halt ? "R8" : (m_pc == 2 ? "R6" : (exp_word(m_pc) == 16'h0 ? "R7" : "R4"));
      chk(m_halt ? 16'h0000 : exp_word(m_pc), tag);
      n_cmp++;
      if (ctrl_word !== mid) begin
        n_bad++;
        $display("FAIL R9: ctrl_word=%h expected %h (value after falling edge)", ctrl_word, mid);
      end
      n_cmp++;
      if (ctrl_word[2:0] !== 3'b000) begin
        n_bad++;
        $display("FAIL R3: spare bits=%b expected 000", ctrl_word[2:0]);
      end
      #1;
      rst = (($urandom % 150) == 0) || (m_halt && (($urandom % 4) == 0));
      r = int'($urandom % 20);
      if (r < 16) opcode = 4'(r);
      else opcode = 4'(1 + (r % 3));
    end
    finish_run();
  end
endmodule